// File: doc/BRIEF.md
# Flash command interface controller

This block sits on the device side of a parallel NOR flash bus. Bus write cycles are turned into commands, and the block runs block erases and word programs on a small internal array of parameterized size. A status byte reports progress and faults, and a ready/busy pin follows that byte's ready bit. Reads return either array contents or the status byte, depending on the read mode that the last command chose.

An erase needs two writes: a setup code, then a confirm code whose address selects the block. This keeps a single stray write from wiping a block. Error bits are set per cause and accumulate until a clear command is written. While an erase is running, the host can halt it, then read or program words in other blocks. A program started under a halted erase can itself be halted and resumed. The erase resumes only after that program is finished.

A write is taken on the first clock where chip enable and write enable are both low after write enable was high. Operation lengths and the halt latency are counted in clock cycles.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, `sts` is high, every array word reads 0xFFFF and reads return array data.
- R2: Writing 0x20 and then 0xD0 to an address inside a block erases only that block. When the erase ends, each of its words reads 0xFFFF and all other words are unchanged.
- R3: Status byte bits: bit 7 = ready, bit 6 = erase halted, bit 5 = erase fault, bit 4 = program fault, bit 3 = program-voltage fault, bit 1 = lock fault, bit 0 = program halted. Any accepted erase, program, suspend or resume sequence, and the command 0x70, switch reads to return {8'h00, status}. Reads keep returning status until 0xFF is written while the block is ready.
- R4: While an erase or program is running, bit 7 is 0 and `sts` is low. Both return to 1 when no operation is running.
- R5: An erase setup followed by any code other than 0xD0 sets bits 5 and 4 and erases nothing.
- R6: With `vpen_ok` low, an erase confirm sets bits 5 and 3 and a program sets bits 4 and 3. The array is not changed in either case.
- R7: An erase confirm or a program aimed at a block whose `blk_lock` bit is set sets bits 5 and 1 (erase) or bits 4 and 1 (program). The block is not changed.
- R8: Writing 0x40 and then a data word programs that word. The stored word becomes the old value ANDed with the data.
- R9: Error bits add up across operations. Command 0x50 clears bits 5 to 1.
- R10: Writing 0xB0 during an erase halts it after SUSP_LAT cycles. The status byte then reads 0xC0. During the halt, array reads are allowed and other blocks can be programmed; such a program shows status 0x40 while it runs. A program aimed at the halted block sets bit 4.
- R11: Writing 0xB0 during a program under a halted erase halts that program (status 0xC1). Writing 0xD0 then resumes the program. Writing 0xD0 while that program is running or halted never resumes the erase.
- R12: A 0xB0 arriving in the same cycle as the final count of the running operation is ignored. The operation completes and no halt bit is set.
- R13: While an operation runs, every write other than 0xB0 and 0x70 is ignored. The read mode and the status error bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address; upper bits select the block |
| din | input | DW | Write data; low byte carries command codes |
| vpen_ok | input | 1 | Program voltage is valid |
| blk_lock | input | NBLK | Per-block lock bits |
| dout | output | DW | Read data (zero unless ce_n and oe_n are low) |
| sts | output | 1 | High when ready, low while busy |

## Verification
The risky coincidence is a halt command landing in the exact cycle where the running erase reaches its final count. Either the halt wins or the completion wins, and the block must pick completion. The bench counts clock edges from the confirm strobe so that the 0xB0 write strobe falls on the erase's last cycle. It then checks that the status reads 0x80 with the halt bit clear and that every word of the block is erased. A second coincidence is also exercised: a resume command while both a program and a halted erase are pending. The bench checks that the erase stays halted until the program has drained.

// File: rtl/ncc_pkg.sv
package ncc_pkg;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_HALT    = 8'hB0;
  localparam logic [7:0] OP_PROGRAM = 8'h40;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  typedef enum logic [1:0] {CS_IDLE, CS_ERASE_ARM, CS_PROG_ARM} cmd_st_e;
  typedef enum logic [1:0] {ES_IDLE, ES_RUN, ES_HALTING, ES_HALTED} ers_st_e;
  typedef enum logic [1:0] {PS_IDLE, PS_RUN, PS_HALTED} prg_st_e;
  typedef enum logic {RM_ARRAY, RM_STATUS} rd_mode_e;
endpackage

// File: rtl/ncc_strobe.sv
module ncc_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_stb
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  // one strobe per write pulse: enable low now, high on the previous edge
  assign wr_stb = !ce_n && !we_n && we_q;
endmodule

// File: rtl/ncc_array.sv
module ncc_array #(
  parameter int NBLK = 8,
  parameter int WPB  = 16,
  parameter int DW   = 16,
  localparam int NW  = NBLK * WPB,
  localparam int AW  = $clog2(NW),
  localparam int BW  = $clog2(NBLK),
  localparam int WB  = $clog2(WPB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ers_fire,
  input  logic [BW-1:0] ers_blk,
  input  logic          prg_fire,
  input  logic [AW-1:0] prg_addr,
  input  logic [DW-1:0] prg_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] mem_q [NW];
  logic [DW-1:0] mem_d [NW];
  logic [NW-1:0] mem_en;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      mem_en[w] = 1'b0;
      mem_d[w]  = mem_q[w];
      if (ers_fire && (ers_blk == BW'(w / WPB))) begin
        mem_en[w] = 1'b1;
        mem_d[w]  = '1;
      end else if (prg_fire && (prg_addr == AW'(w))) begin
        mem_en[w] = 1'b1;
        mem_d[w]  = mem_q[w] & prg_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) mem_q[w] <= '1;
    end else begin
      for (int w = 0; w < NW; w++) if (mem_en[w]) mem_q[w] <= mem_d[w];
    end
  end

  assign rd_word = mem_q[rd_addr];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(ers_fire && prg_fire)); // R2
  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    ers_fire |=> (mem_q[{$past(ers_blk), {WB{1'b0}}}] == {DW{1'b1}})); // R2
endmodule

// File: rtl/ncc_seq.sv
module ncc_seq
  import ncc_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int WPB       = 16,
  parameter int DW        = 16,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 12,
  parameter int SUSP_LAT  = 4,
  localparam int AW  = $clog2(NBLK * WPB),
  localparam int BW  = $clog2(NBLK),
  localparam int WB  = $clog2(WPB),
  localparam int ECW = $clog2(ERASE_CYC + 1),
  localparam int PCW = $clog2(PROG_CYC + 1),
  localparam int LCW = $clog2(SUSP_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            vpen_ok,
  input  logic [NBLK-1:0] blk_lock,
  output logic            rd_status,
  output logic [7:0]      sr,
  output logic            ers_fire,
  output logic [BW-1:0]   ers_blk,
  output logic            prg_fire,
  output logic [AW-1:0]   prg_addr,
  output logic [DW-1:0]   prg_data
);
  cmd_st_e  cst_q, cst_d;
  ers_st_e  est_q, est_d;
  prg_st_e  pst_q, pst_d;
  rd_mode_e rmode_q, rmode_d;
  logic [ECW-1:0] ecnt_q, ecnt_d;
  logic [LCW-1:0] lcnt_q, lcnt_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [BW-1:0]  eblk_q;
  logic [AW-1:0]  paddr_q;
  logic [DW-1:0]  pdata_q;
  logic           ld_ers, ld_prg;
  logic           e_err_q, e_err_d, p_err_q, p_err_d;
  logic           v_err_q, v_err_d, l_err_q, l_err_d;
  logic           busy, ready;
  logic [7:0]     cmd;
  logic [BW-1:0]  wblk;

  assign cmd   = wr_data[7:0];
  assign wblk  = wr_addr[AW-1:WB];
  assign busy  = (est_q == ES_RUN) || (est_q == ES_HALTING) || (pst_q == PS_RUN);
  assign ready = !busy;

  always_comb begin
    cst_d = cst_q;  est_d = est_q;  pst_d = pst_q;  rmode_d = rmode_q;
    ecnt_d = ecnt_q;  lcnt_d = lcnt_q;  pcnt_d = pcnt_q;
    e_err_d = e_err_q;  p_err_d = p_err_q;  v_err_d = v_err_q;  l_err_d = l_err_q;
    ld_ers = 1'b0;  ld_prg = 1'b0;  ers_fire = 1'b0;  prg_fire = 1'b0;

    // erase engine
    case (est_q)
      ES_RUN: begin
        if (ecnt_q == '0) begin
          ers_fire = 1'b1;
          est_d    = ES_IDLE;
        end else begin
          ecnt_d = ecnt_q - 1'b1;
        end
      end
      ES_HALTING: begin
        if (ecnt_q == '0) begin
          ers_fire = 1'b1;
          est_d    = ES_IDLE;
        end else begin
          ecnt_d = ecnt_q - 1'b1;
          if (lcnt_q == '0) est_d = ES_HALTED;
          else              lcnt_d = lcnt_q - 1'b1;
        end
      end
      default: ;
    endcase

    // program engine
    if (pst_q == PS_RUN) begin
      if (pcnt_q == '0) begin
        prg_fire = 1'b1;
        pst_d    = PS_IDLE;
      end else begin
        pcnt_d = pcnt_q - 1'b1;
      end
    end

    // command decode
    if (wr_stb) begin
      case (cst_q)
        CS_ERASE_ARM: begin
          cst_d   = CS_IDLE;
          rmode_d = RM_STATUS;
          if (cmd != OP_CONFIRM) begin
            e_err_d = 1'b1;  p_err_d = 1'b1;
          end else if (!vpen_ok) begin
            e_err_d = 1'b1;  v_err_d = 1'b1;
          end else if (blk_lock[wblk]) begin
            e_err_d = 1'b1;  l_err_d = 1'b1;
          end else begin
            est_d  = ES_RUN;
            ecnt_d = ECW'(ERASE_CYC - 1);
            ld_ers = 1'b1;
          end
        end
        CS_PROG_ARM: begin
          cst_d   = CS_IDLE;
          rmode_d = RM_STATUS;
          if (!vpen_ok) begin
            p_err_d = 1'b1;  v_err_d = 1'b1;
          end else if (blk_lock[wblk]) begin
            p_err_d = 1'b1;  l_err_d = 1'b1;
          end else if ((est_q != ES_IDLE) && (wblk == eblk_q)) begin
            p_err_d = 1'b1;
          end else begin
            pst_d  = PS_RUN;
            pcnt_d = PCW'(PROG_CYC - 1);
            ld_prg = 1'b1;
          end
        end
        default: begin
          if (busy) begin
            if (cmd == OP_HALT) begin
              rmode_d = RM_STATUS;
              if (pst_q == PS_RUN) begin
                if (pcnt_q != '0) pst_d = PS_HALTED;
              end else if ((est_q == ES_RUN) && (ecnt_q != '0)) begin
                est_d  = ES_HALTING;
                lcnt_d = LCW'(SUSP_LAT - 1);
              end
            end else if (cmd == OP_STATUS) begin
              rmode_d = RM_STATUS;
            end
          end else begin
            case (cmd)
              OP_ARRAY:  rmode_d = RM_ARRAY;
              OP_STATUS: rmode_d = RM_STATUS;
              OP_CLEAR: begin
                e_err_d = 1'b0;  p_err_d = 1'b0;  v_err_d = 1'b0;  l_err_d = 1'b0;
              end
              OP_ERASE: begin
                if ((est_q == ES_IDLE) && (pst_q == PS_IDLE)) begin
                  cst_d   = CS_ERASE_ARM;
                  rmode_d = RM_STATUS;
                end
              end
              OP_PROGRAM: begin
                if (pst_q == PS_IDLE) begin
                  cst_d   = CS_PROG_ARM;
                  rmode_d = RM_STATUS;
                end
              end
              OP_CONFIRM: begin
                rmode_d = RM_STATUS;
                if (pst_q == PS_HALTED)                              pst_d = PS_RUN;
                else if ((est_q == ES_HALTED) && (pst_q == PS_IDLE)) est_d = ES_RUN;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst_q   <= CS_IDLE;
      est_q   <= ES_IDLE;
      pst_q   <= PS_IDLE;
      rmode_q <= RM_ARRAY;
      ecnt_q  <= '0;
      lcnt_q  <= '0;
      pcnt_q  <= '0;
      e_err_q <= 1'b0;
      p_err_q <= 1'b0;
      v_err_q <= 1'b0;
      l_err_q <= 1'b0;
    end else begin
      cst_q   <= cst_d;
      est_q   <= est_d;
      pst_q   <= pst_d;
      rmode_q <= rmode_d;
      ecnt_q  <= ecnt_d;
      lcnt_q  <= lcnt_d;
      pcnt_q  <= pcnt_d;
      e_err_q <= e_err_d;
      p_err_q <= p_err_d;
      v_err_q <= v_err_d;
      l_err_q <= l_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eblk_q  <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      if (ld_ers) eblk_q <= wblk;
      if (ld_prg) begin
        paddr_q <= wr_addr;
        pdata_q <= wr_data;
      end
    end
  end

  assign rd_status = (rmode_q == RM_STATUS);
  assign sr        = {ready, est_q == ES_HALTED, e_err_q, p_err_q, v_err_q, 1'b0,
                      l_err_q, pst_q == PS_HALTED};
  assign ers_blk   = eblk_q;
  assign prg_addr  = paddr_q;
  assign prg_data  = pdata_q;

  AST_READY_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_stb)); // R4
  AST_ERR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_err_q) |-> $past(wr_stb)); // R5
  AST_HALT_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (est_q == ES_HALTED) |=> $stable(eblk_q)); // R10
  AST_PROG_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (pst_q != PS_IDLE) |-> ((est_q == ES_IDLE) || (est_q == ES_HALTED))); // R11
  AST_RESUME_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((est_q == ES_HALTED) && (pst_q != PS_IDLE)) |=> (est_q == ES_HALTED)); // R11
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy && (cmd != OP_HALT) && (cmd != OP_STATUS))
      |=> ($stable(rmode_q) && $stable({e_err_q, p_err_q, v_err_q, l_err_q}))); // R13
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int NBLK      = 8,
  parameter int WPB       = 16,
  parameter int DW        = 16,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 12,
  parameter int SUSP_LAT  = 4,
  localparam int AW = $clog2(NBLK * WPB),
  localparam int BW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  input  logic            vpen_ok,
  input  logic [NBLK-1:0] blk_lock,
  output logic [DW-1:0]   dout,
  output logic            sts
);
  logic          wr_stb, rd_status, ers_fire, prg_fire;
  logic [7:0]    sr;
  logic [BW-1:0] ers_blk;
  logic [AW-1:0] prg_addr;
  logic [DW-1:0] prg_data, rd_word;

  ncc_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .wr_stb(wr_stb)
  );

  ncc_seq #(
    .NBLK(NBLK), .WPB(WPB), .DW(DW),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(addr), .wr_data(din),
    .vpen_ok(vpen_ok), .blk_lock(blk_lock), .rd_status(rd_status), .sr(sr),
    .ers_fire(ers_fire), .ers_blk(ers_blk), .prg_fire(prg_fire),
    .prg_addr(prg_addr), .prg_data(prg_data)
  );

  ncc_array #(.NBLK(NBLK), .WPB(WPB), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .ers_fire(ers_fire), .ers_blk(ers_blk),
    .prg_fire(prg_fire), .prg_addr(prg_addr), .prg_data(prg_data),
    .rd_addr(addr), .rd_word(rd_word)
  );

  assign sts  = sr[7];
  assign dout = (!ce_n && !oe_n) ? (rd_status ? {{(DW-8){1'b0}}, sr} : rd_word) : '0;

  AST_PIN_HIGH_WHEN_IDLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sts); // R1
endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;
  localparam int NBLK = 8, WPB = 16, DW = 16;
  localparam int ERASE_CYC = 40, PROG_CYC = 12, SUSP_LAT = 4;
  localparam int NW = NBLK * WPB;
  localparam int AW = $clog2(NW);

  logic clk = 1'b0, rst_n;
  logic ce_n, we_n, oe_n, vpen_ok;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic [NBLK-1:0] blk_lock;
  logic sts;
  int checks = 0, fails = 0;
  logic [15:0] mdl [NW];
  logic [15:0] rv;

  always #2 clk = ~clk;

  nor_cmd_ctrl #(.NBLK(NBLK), .WPB(WPB), .DW(DW), .ERASE_CYC(ERASE_CYC),
    .PROG_CYC(PROG_CYC), .SUSP_LAT(SUSP_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .vpen_ok(vpen_ok), .blk_lock(blk_lock),
    .dout(dout), .sts(sts));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
    #1 d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready();
    for (int t = 0; t < 4000 && sts !== 1'b1; t++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_erase_sr(input bit vp, input bit lk);
    return 8'h80 | (!vp ? 8'h28 : (lk ? 8'h22 : 8'h00));
  endfunction

  function automatic logic [7:0] exp_prog_sr(input bit vp, input bit lk);
    return 8'h80 | (!vp ? 8'h18 : (lk ? 8'h12 : 8'h00));
  endfunction

  task automatic prog(input int a, input logic [15:0] d);
    wr(a, 16'h0040); wr(a, d);
    wait_ready();
    mdl[a] = mdl[a] & d;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0; vpen_ok = 1'b1; blk_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 sts after reset", 32'(sts), 32'd1);
    rd(17, rv); chk("R1 array reads ones", 32'(rv), 32'hFFFF);
    wr(0, 16'h0070); rd(0, rv); chk("R3 status after 0x70", 32'(rv), 32'h80);
    wr(0, 16'h00FF); rd(5, rv); chk("R3 back to array", 32'(rv), 32'hFFFF);

    // R8 program, R5 bad sequence
    prog(33, 16'h1234); prog(85, 16'hF0F0);
    wr(0, 16'h00FF); rd(33, rv); chk("R8 programmed word", 32'(rv), 32'h1234);
    wr(32, 16'h0020); wr(32, 16'h0070); rd(0, rv);
    chk("R5 bad erase sequence", 32'(rv), 32'hB0);
    wr(0, 16'h00FF); rd(33, rv); chk("R5 block unchanged", 32'(rv), 32'h1234);
    wr(0, 16'h0050); wr(0, 16'h0070); rd(0, rv); chk("R9 clear", 32'(rv), 32'h80);

    // R7 lock then R6 voltage, accumulating; R9
    blk_lock = 8'h04;
    wr(32, 16'h0020); wr(32, 16'h00D0); rd(0, rv); chk("R7 locked erase", 32'(rv), 32'hA2);
    blk_lock = '0; vpen_ok = 1'b0;
    wr(32, 16'h0020); wr(32, 16'h00D0); rd(0, rv); chk("R9 faults accumulate R6", 32'(rv), 32'hAA);
    vpen_ok = 1'b1;
    wr(0, 16'h00FF); rd(33, rv); chk("R6 R7 no erase", 32'(rv), 32'h1234);
    wr(0, 16'h0050);

    // R10 R11 R13 halt flow on block 2
    wr(40, 16'h0020); wr(40, 16'h00D0);
    chk("R4 sts low while erasing", 32'(sts), 32'd0);
    rd(0, rv); chk("R4 status busy", 32'(rv), 32'h00);
    wr(0, 16'h00FF); wr(0, 16'h0050); rd(33, rv);
    chk("R13 writes ignored while busy", 32'(rv), 32'h00);
    wr(0, 16'h00B0); rd(0, rv); chk("R10 halt latency", 32'(rv), 32'h00);
    wait_ready(); rd(0, rv); chk("R10 halted status", 32'(rv), 32'hC0);
    wr(0, 16'h00FF); rd(85, rv); chk("R10 read other block", 32'(rv), 32'hF0F0);
    rd(33, rv); chk("R10 halted block not erased yet", 32'(rv), 32'h1234);
    wr(86, 16'h0040); wr(86, 16'h0F0F); rd(0, rv);
    chk("R10 program under halt", 32'(rv), 32'h40);
    wr(0, 16'h00B0); rd(0, rv); chk("R11 program halted", 32'(rv), 32'hC1);
    wr(0, 16'h00D0); rd(0, rv); chk("R11 program resumed first", 32'(rv), 32'h40);
    wr(0, 16'h00D0); wait_ready(); rd(0, rv);
    chk("R11 erase stays halted", 32'(rv), 32'hC0);
    mdl[86] = mdl[86] & 16'h0F0F;
    wr(0, 16'h00FF); rd(86, rv); chk("R11 program result", 32'(rv), 32'(mdl[86]));
    wr(35, 16'h0040); wr(35, 16'h0000); rd(0, rv);
    chk("R10 program into halted block", 32'(rv), 32'hD0);
    wr(0, 16'h0050); wr(0, 16'h00D0); rd(0, rv); chk("R4 erase resumed busy", 32'(rv), 32'h00);
    wait_ready(); rd(0, rv); chk("R2 erase done", 32'(rv), 32'h80);
    for (int w = 32; w < 48; w++) mdl[w] = 16'hFFFF;
    wr(0, 16'h00FF);
    for (int w = 32; w < 48; w++) begin
      rd(w, rv); chk("R2 erased word", 32'(rv), 32'hFFFF);
    end
    rd(85, rv); chk("R2 neighbour intact", 32'(rv), 32'(mdl[85]));

    // R12 halt in final erase cycle
    prog(49, 16'h00AA);
    wr(48, 16'h0020); wr(48, 16'h00D0);
    repeat (ERASE_CYC - 2) @(negedge clk);
    wr(0, 16'h00B0);
    wait_ready(); rd(0, rv); chk("R12 completes without halt", 32'(rv), 32'h80);
    wr(0, 16'h00FF); rd(49, rv); chk("R12 block erased", 32'(rv), 32'hFFFF);
    mdl[49] = 16'hFFFF;

    // constrained random programs and erases
    for (int i = 0; i < 24; i++) begin
      int a;
      logic [15:0] d;
      bit vp, lk, ers;
      logic [7:0] esr;
      a = int'($urandom % NW); d = 16'($urandom);
      vp = ($urandom % 4) != 0;
      blk_lock = 8'($urandom & $urandom & $urandom);
      vpen_ok = vp; lk = blk_lock[a / WPB]; ers = ($urandom % 5) == 0;
      wr(0, 16'h0050);
      if (ers) begin
        wr(a, 16'h0020); wr(a, 16'h00D0); esr = exp_erase_sr(vp, lk);
      end else begin
        wr(a, 16'h0040); wr(a, d); esr = exp_prog_sr(vp, lk);
      end
      wait_ready(); rd(0, rv);
      chk(ers ? "R2 R6 R7 random erase status" : "R8 R6 R7 random program status",
          32'(rv), 32'(esr));
      if (esr == 8'h80) begin
        if (ers) for (int w = 0; w < WPB; w++) mdl[(a / WPB) * WPB + w] = 16'hFFFF;
        else mdl[a] = mdl[a] & d;
      end
      wr(0, 16'h00FF);
      rd(a, rv); chk("R8 random array word", 32'(rv), 32'(mdl[a]));
    end
    vpen_ok = 1'b1; blk_lock = '0;
    finish_up();
  end
endmodule